// File: doc/BRIEF.md
# Streaming Substring Position Finder

This block finds every place where a short pattern string occurs inside a longer text string and reports each starting position on a result stream. Both strings arrive on one 32-bit valid/ready input stream. Each data beat carries four 8-bit characters, and the block separates them again before comparing. Before the characters of each string, the host sends a length header word. The block keeps the text in a local word memory. It then derives the pattern's fallback table in hardware, one table step per cycle. Finally it walks the text once, and after a mismatch it moves the pattern index back through the table, so the text index never moves backwards.

Two modes exist. In the streaming mode, each job sends a text followed by a pattern. In the resident mode, a job sends only a pattern, which is checked against the text left in memory by the last streaming-mode job. A host can load a long text once and then test many short patterns against it. The result stream carries one 32-bit zero-based start offset per occurrence, then an all-ones marker beat with the last flag set.

Top module: `kmp_stream_matcher`

## Requirements
- R1: Character n (n = 0..3) of an input data beat is taken from bits [8n+7:8n], so the lowest byte comes first in string order. Unused bytes in a string's final beat are ignored.
- R2: A header beat carries the string length in bits [15:0]. The data beats that follow it number the ceiling of length/4. In streaming mode (`resident_mode` low when the first header is accepted) the job is: text header, text beats, pattern header, pattern beats.
- R3: Every occurrence of the pattern in the text is reported as its zero-based start offset, in ascending order. Overlapping occurrences are included, and so are occurrences that end on the last text character. Patterns may be up to PAT_MAX characters long.
- R4: Results are correct for patterns that overlap themselves, such as "aab" inside "aaab", where a partial match must fall back without skipping a candidate position.
- R5: After the last offset, exactly one beat is sent with value 0xFFFFFFFF and `res_last` high. This happens also when there are no occurrences. Offset beats have `res_last` low. Once the end beat is accepted, the block accepts input again.
- R6: In resident mode (`resident_mode` high when the header is accepted), the job carries only a pattern header and pattern beats. The pattern is matched against the text stored by the most recent streaming-mode job.
- R7: A resident-mode job issued before any text has been loaded since reset still consumes its pattern, and then returns only the end beat.
- R8: `in_ready` is low from the acceptance of a job's final beat until its end beat has been accepted. It is never high while `res_valid` is high.
- R9: While `res_valid` is high and `res_ready` is low, `res_data` and `res_last` hold steady and `res_valid` stays high. No result is lost or repeated under backpressure.
- R10: A pattern of length zero, or a pattern longer than the text, gives only the end beat.
- R11: After reset, `in_ready` is high and `res_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| resident_mode | input | 1 | High: job reuses the stored text; sampled with the first header |
| in_data | input | 32 | Header or four packed characters |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block accepts an input beat |
| res_data | output | 32 | Match offset, or 0xFFFFFFFF end marker |
| res_valid | output | 1 | Result beat present |
| res_ready | input | 1 | Consumer accepts the result beat |
| res_last | output | 1 | Marks the end beat |

## Verification
The bench sweeps every pattern of length one to three over a two-letter alphabet against a stored text that contains long runs of one letter. This exposes a fallback that resets to zero and drops overlapping hits, and an off-by-one in the table that reports false hits. It uses a text length that is not a multiple of four, which catches a swapped byte order or a dropped tail character, and a 64-character pattern taken from a longer text, which catches a table-width or depth fault. It also issues a resident job straight after reset, an empty pattern, and a pattern longer than its text. A design that scanned stale memory in these cases would emit offsets. It throttles `res_ready` from a shift register, so any beat that changes while stalled, or any result lost or sent twice, shows up in the collected list.

// File: rtl/kmp_pkg.sv
package kmp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TEXT,
        ST_PHDR,
        ST_PAT,
        ST_BUILD,
        ST_SCAN,
        ST_EMIT,
        ST_END
    } kmp_state_e;

    localparam logic [31:0] END_MARK = 32'hFFFF_FFFF;

endpackage

// File: rtl/kmp_word_ram.sv
module kmp_word_ram #(
    parameter int WORDS = 16,
    parameter int WIDTH = 32,
    parameter int NRD   = 1,
    localparam int AW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [AW-1:0]        waddr,
    input  logic [WIDTH-1:0]     wdata,
    input  logic [NRD*AW-1:0]    raddr,
    output logic [NRD*WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // asynchronous read ports, one per requested lane
    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g*WIDTH +: WIDTH] = mem[raddr[g*AW +: AW]];
    end

endmodule

// File: rtl/kmp_byte_lane.sv
module kmp_byte_lane (
    input  logic [31:0] word,
    input  logic [1:0]  sel,
    output logic [7:0]  ch
);

    // lowest byte is the earliest character
    always_comb begin
        unique case (sel)
            2'd0:    ch = word[7:0];
            2'd1:    ch = word[15:8];
            2'd2:    ch = word[23:16];
            default: ch = word[31:24];
        endcase
    end

endmodule

// File: rtl/kmp_stream_matcher.sv
module kmp_stream_matcher
    import kmp_pkg::*;
#(
    parameter int PAT_MAX  = 64,
    parameter int TEXT_MAX = 2048
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        resident_mode,
    input  logic [31:0] in_data,
    input  logic        in_valid,
    output logic        in_ready,
    output logic [31:0] res_data,
    output logic        res_valid,
    input  logic        res_ready,
    output logic        res_last
);

    localparam int PLW    = $clog2(PAT_MAX + 1);
    localparam int TLW    = $clog2(TEXT_MAX + 1);
    localparam int PWORDS = PAT_MAX / 4;
    localparam int TWORDS = TEXT_MAX / 4;
    localparam int PAW    = $clog2(PWORDS);
    localparam int TAW    = $clog2(TWORDS);
    localparam int PIW    = $clog2(PAT_MAX);

    typedef struct packed {
        kmp_state_e     state;
        logic [TLW-1:0] text_len;
        logic           text_ok;
        logic [PLW-1:0] pat_len;
        logic           no_scan;
        logic [TLW-1:0] wcnt;
        logic [TLW-1:0] wtot;
        logic [PLW-1:0] bi;
        logic [PLW-1:0] bk;
        logic [TLW-1:0] tj;
        logic [PLW-1:0] pq;
        logic [31:0]    out_data;
    } kmp_regs_t;

    kmp_regs_t r_q, r_d;

    // memory ports
    logic             text_we;
    logic [TAW-1:0]   text_waddr;
    logic [TAW-1:0]   text_raddr;
    logic [31:0]      text_rword;
    logic             pat_we;
    logic [PAW-1:0]   pat_waddr;
    logic [2*PAW-1:0] pat_raddr;
    logic [63:0]      pat_rword;
    logic             fail_we;
    logic [PIW-1:0]   fail_waddr;
    logic [PLW-1:0]   fail_wdata;
    logic [PIW-1:0]   fail_raddr;
    logic [PLW-1:0]   fail_rd;

    logic [7:0]     tch, pch0, pch1;
    logic [PLW-1:0] pidx0, pidx1;
    logic [PLW-1:0] bk_m1, pq_m1;
    logic           scan_eq;

    kmp_word_ram #(.WORDS(TWORDS), .WIDTH(32), .NRD(1)) u_text_ram (
        .clk(clk), .we(text_we), .waddr(text_waddr), .wdata(in_data),
        .raddr(text_raddr), .rdata(text_rword)
    );

    kmp_word_ram #(.WORDS(PWORDS), .WIDTH(32), .NRD(2)) u_pat_ram (
        .clk(clk), .we(pat_we), .waddr(pat_waddr), .wdata(in_data),
        .raddr(pat_raddr), .rdata(pat_rword)
    );

    kmp_word_ram #(.WORDS(PAT_MAX), .WIDTH(PLW), .NRD(1)) u_fail_ram (
        .clk(clk), .we(fail_we), .waddr(fail_waddr), .wdata(fail_wdata),
        .raddr(fail_raddr), .rdata(fail_rd)
    );

    kmp_byte_lane u_text_lane (.word(text_rword),      .sel(r_q.tj[1:0]), .ch(tch));
    kmp_byte_lane u_pat_lane0 (.word(pat_rword[31:0]),  .sel(pidx0[1:0]),  .ch(pch0));
    kmp_byte_lane u_pat_lane1 (.word(pat_rword[63:32]), .sel(pidx1[1:0]),  .ch(pch1));

    // read addressing depends only on registered state
    always_comb begin
        bk_m1      = r_q.bk - PLW'(1);
        pq_m1      = r_q.pq - PLW'(1);
        pidx0      = (r_q.state == ST_BUILD) ? r_q.bi : r_q.pq;
        pidx1      = r_q.bk;
        text_raddr = r_q.tj[TAW+1:2];
        pat_raddr  = {pidx1[PAW+1:2], pidx0[PAW+1:2]};
        scan_eq    = (tch == pch0);
        if (r_q.state == ST_BUILD) begin
            fail_raddr = bk_m1[PIW-1:0];
        end else if (scan_eq) begin
            fail_raddr = r_q.pq[PIW-1:0];
        end else begin
            fail_raddr = pq_m1[PIW-1:0];
        end
    end

    assign in_ready  = (r_q.state == ST_IDLE) || (r_q.state == ST_TEXT) ||
                       (r_q.state == ST_PHDR) || (r_q.state == ST_PAT);
    assign res_valid = (r_q.state == ST_EMIT) || (r_q.state == ST_END);
    assign res_last  = (r_q.state == ST_END);
    assign res_data  = r_q.out_data;

    logic           in_fire;
    logic           take_phdr;
    logic [15:0]    hdr;
    logic [TLW-1:0] hdr_tlen;
    logic [PLW-1:0] hdr_plen;
    logic [TLW:0]   tsum;
    logic [PLW:0]   psum;

    always_comb begin
        r_d        = r_q;
        in_fire    = in_valid && in_ready;
        text_we    = 1'b0;
        text_waddr = r_q.wcnt[TAW-1:0];
        pat_we     = 1'b0;
        pat_waddr  = r_q.wcnt[PAW-1:0];
        fail_we    = 1'b0;
        fail_waddr = r_q.bi[PIW-1:0];
        fail_wdata = '0;
        take_phdr  = 1'b0;

        hdr      = in_data[15:0];
        hdr_tlen = (hdr > 16'(TEXT_MAX)) ? TLW'(TEXT_MAX) : hdr[TLW-1:0];
        hdr_plen = (hdr > 16'(PAT_MAX))  ? PLW'(PAT_MAX)  : hdr[PLW-1:0];
        tsum     = {1'b0, hdr_tlen} + (TLW+1)'(3);
        psum     = {1'b0, hdr_plen} + (PLW+1)'(3);

        unique case (r_q.state)
            ST_IDLE: begin
                if (in_fire) begin
                    if (resident_mode) begin
                        take_phdr = 1'b1;
                    end else begin
                        r_d.text_len = hdr_tlen;
                        r_d.wtot     = TLW'(tsum >> 2);
                        r_d.wcnt     = '0;
                        r_d.text_ok  = (hdr_tlen == '0);
                        r_d.state    = (hdr_tlen == '0) ? ST_PHDR : ST_TEXT;
                    end
                end
            end
            ST_TEXT: begin
                if (in_fire) begin
                    text_we  = 1'b1;
                    r_d.wcnt = r_q.wcnt + TLW'(1);
                    if (r_q.wcnt + TLW'(1) == r_q.wtot) begin
                        r_d.text_ok = 1'b1;
                        r_d.state   = ST_PHDR;
                    end
                end
            end
            ST_PHDR: begin
                if (in_fire) begin
                    take_phdr = 1'b1;
                end
            end
            ST_PAT: begin
                if (in_fire) begin
                    pat_we   = 1'b1;
                    r_d.wcnt = r_q.wcnt + TLW'(1);
                    if (r_q.wcnt + TLW'(1) == r_q.wtot) begin
                        // first table entry is always zero
                        fail_we    = 1'b1;
                        fail_waddr = '0;
                        fail_wdata = '0;
                        r_d.bi     = PLW'(1);
                        r_d.bk     = '0;
                        if (r_q.no_scan) begin
                            r_d.out_data = END_MARK;
                            r_d.state    = ST_END;
                        end else begin
                            r_d.state = ST_BUILD;
                        end
                    end
                end
            end
            ST_BUILD: begin
                if (r_q.bi >= r_q.pat_len) begin
                    r_d.tj    = '0;
                    r_d.pq    = '0;
                    r_d.state = ST_SCAN;
                end else if (pch0 == pch1) begin
                    fail_we    = 1'b1;
                    fail_wdata = r_q.bk + PLW'(1);
                    r_d.bk     = r_q.bk + PLW'(1);
                    r_d.bi     = r_q.bi + PLW'(1);
                end else if (r_q.bk != '0) begin
                    r_d.bk = fail_rd;
                end else begin
                    fail_we    = 1'b1;
                    fail_wdata = '0;
                    r_d.bi     = r_q.bi + PLW'(1);
                end
            end
            ST_SCAN: begin
                if (r_q.tj == r_q.text_len) begin
                    r_d.out_data = END_MARK;
                    r_d.state    = ST_END;
                end else if (scan_eq) begin
                    r_d.tj = r_q.tj + TLW'(1);
                    if (r_q.pq + PLW'(1) == r_q.pat_len) begin
                        r_d.out_data = 32'(r_q.tj) + 32'd1 - 32'(r_q.pat_len);
                        r_d.pq       = fail_rd;
                        r_d.state    = ST_EMIT;
                    end else begin
                        r_d.pq = r_q.pq + PLW'(1);
                    end
                end else if (r_q.pq != '0) begin
                    r_d.pq = fail_rd;
                end else begin
                    r_d.tj = r_q.tj + TLW'(1);
                end
            end
            ST_EMIT: begin
                if (res_ready) begin
                    r_d.state = ST_SCAN;
                end
            end
            ST_END: begin
                if (res_ready) begin
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase

        if (take_phdr) begin
            r_d.pat_len = hdr_plen;
            r_d.wtot    = TLW'(psum >> 2);
            r_d.wcnt    = '0;
            r_d.no_scan = (resident_mode && (r_q.state == ST_IDLE) && !r_q.text_ok) ||
                          (hdr_plen == '0);
            if (hdr_plen == '0) begin
                r_d.out_data = END_MARK;
                r_d.state    = ST_END;
            end else begin
                r_d.state = ST_PAT;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/kmp_matcher_checks.sv
module kmp_matcher_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        in_ready,
    input logic [31:0] res_data,
    input logic        res_valid,
    input logic        res_ready,
    input logic        res_last
);

    logic        have_off_q;
    logic [31:0] last_off_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_off_q <= 1'b0;
            last_off_q <= '0;
        end else if (res_valid && res_ready) begin
            have_off_q <= !res_last;
            last_off_q <= res_data;
        end
    end

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(res_last));

    assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && res_valid));

    assert_end_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_last |-> res_data == 32'hFFFF_FFFF);

    assert_reopen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_ready && res_last |=> in_ready && !res_valid);

    assert_ascending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_last && have_off_q |-> res_data > last_off_q);

endmodule

bind kmp_stream_matcher kmp_matcher_checks u_checks (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .res_data(res_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_last(res_last)
);

// File: tb/kmp_stream_matcher_test.sv
`timescale 1ns/1ps
module kmp_stream_matcher_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        resident_mode = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] res_data;
    logic        res_valid;
    logic        res_ready = 1'b0;
    logic        res_last;

    always #2.5 clk = ~clk;

    kmp_stream_matcher uut (
        .clk(clk), .rst_n(rst_n), .resident_mode(resident_mode),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .res_data(res_data), .res_valid(res_valid), .res_ready(res_ready),
        .res_last(res_last)
    );

    int checks = 0;
    int failures = 0;

    logic [7:0] tbuf [256];
    logic [7:0] pbuf [64];
    int tlen = 0;
    int plen = 0;
    bit model_text_ok = 1'b0;

    int exp_off [256];
    int exp_n;
    int got_off [256];
    int got_n;
    logic [31:0] end_val;
    bit bp_bad, mix_bad;
    logic [7:0] lfsr = 8'hA5;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic send_word(logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic send_text();
        send_word(32'(tlen));
        for (int w = 0; w < (tlen + 3) / 4; w++) begin
            logic [31:0] word;
            for (int b = 0; b < 4; b++)
                word[8*b +: 8] = (4*w + b < tlen) ? tbuf[4*w + b] : 8'h00;
            send_word(word);
        end
    endtask

    task automatic send_pat();
        send_word(32'(plen));
        for (int w = 0; w < (plen + 3) / 4; w++) begin
            logic [31:0] word;
            for (int b = 0; b < 4; b++)
                word[8*b +: 8] = (4*w + b < plen) ? pbuf[4*w + b] : 8'h00;
            send_word(word);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic collect();
        bit done = 1'b0;
        bit stalled = 1'b0;
        logic [31:0] prev = '0;
        got_n = 0;
        bp_bad = 1'b0;
        mix_bad = 1'b0;
        while (!done) begin
            @(negedge clk);
            if (stalled && (!res_valid || res_data != prev)) bp_bad = 1'b1;
            if (res_valid && in_ready) mix_bad = 1'b1;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            res_ready = lfsr[0] | lfsr[3];
            if (res_valid && res_ready) begin
                if (res_last) begin
                    done = 1'b1;
                    end_val = res_data;
                end else if (got_n < 256) begin
                    got_off[got_n] = int'(res_data);
                    got_n++;
                end
                stalled = 1'b0;
            end else begin
                stalled = res_valid;
                prev = res_data;
            end
        end
    endtask

    function automatic void model();
        exp_n = 0;
        if (!model_text_ok || plen == 0) return;
        for (int i = 0; i + plen <= tlen; i++) begin
            bit hit = 1'b1;
            for (int k = 0; k < plen; k++)
                if (tbuf[i + k] != pbuf[k]) hit = 1'b0;
            if (hit) begin
                exp_off[exp_n] = i;
                exp_n++;
            end
        end
    endfunction

    task automatic run_job(bit resident, string req);
        @(negedge clk);
        resident_mode = resident;
        if (!resident) model_text_ok = 1'b1;
        fork
            begin
                if (!resident) send_text();
                send_pat();
            end
            collect();
        join
        model();
        check(got_n == exp_n, req, "offset count", got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++)
            check(got_off[i] == exp_off[i], req, "offset value", got_off[i], exp_off[i]);
        check(end_val == 32'hFFFF_FFFF, "R5", "end marker", end_val, 32'hFFFF_FFFF);
        check(!bp_bad, "R9", "hold under stall", bp_bad, 0);
        check(!mix_bad, "R8", "input closed during output", mix_bad, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(in_ready == 1'b1, "R11", "in_ready after reset", in_ready, 1);
        check(res_valid == 1'b0, "R11", "res_valid after reset", res_valid, 0);

        // R7 resident job with nothing loaded
        tlen = 8;
        for (int i = 0; i < 8; i++) tbuf[i] = "a";
        plen = 1; pbuf[0] = "a";
        run_job(1'b1, "R7");

        // R1 R2 text of 37 characters (tail beat partly used)
        tlen = 37;
        for (int i = 0; i < tlen; i++) tbuf[i] = ((i * 7 + i / 3) % 3 == 0) ? "a" : "b";
        for (int i = 10; i < 16; i++) tbuf[i] = "a";
        tbuf[36] = "b";
        plen = 3; pbuf[0] = "a"; pbuf[1] = "a"; pbuf[2] = "b";
        run_job(1'b0, "R1");

        // R3 R4 R6 sweep of every a/b pattern up to length 3, text resident
        for (int L = 1; L <= 3; L++) begin
            for (int code = 0; code < (1 << L); code++) begin
                plen = L;
                for (int k = 0; k < L; k++) pbuf[k] = code[k] ? "b" : "a";
                run_job(1'b1, "R3");
            end
        end

        // R4 self-overlapping longer pattern
        plen = 4;
        for (int k = 0; k < 4; k++) pbuf[k] = "a";
        run_job(1'b1, "R4");

        // R6 slice taken from an unaligned offset
        plen = 6;
        for (int k = 0; k < 6; k++) pbuf[k] = tbuf[21 + k];
        run_job(1'b1, "R6");

        // R10 empty pattern
        plen = 0;
        run_job(1'b1, "R10");

        // R3 longest pattern against a 200-character text
        tlen = 200;
        for (int i = 0; i < tlen; i++) tbuf[i] = 8'(8'h41 + (i * i + 3 * i) % 5);
        plen = 64;
        for (int k = 0; k < 64; k++) pbuf[k] = tbuf[100 + k];
        run_job(1'b0, "R3");

        // R10 pattern longer than text
        tlen = 3;
        tbuf[0] = "x"; tbuf[1] = "y"; tbuf[2] = "x";
        plen = 5;
        for (int k = 0; k < 5; k++) pbuf[k] = "x";
        run_job(1'b0, "R10");

        // R2 text of length zero in streaming mode
        tlen = 0;
        plen = 1; pbuf[0] = "x";
        run_job(1'b0, "R2");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule